// File: doc/BRIEF.md
# Pattern-Driven Variable Serial Clock Generator

This block produces the serial clock for a serial-peripheral master, derived from the peripheral clock. Two 16-bit divider values set the length of a half period, and each half lasts the divider value plus one peripheral clock. In fixed mode only the first divider is used, so the serial clock frequency is constant.

In variable mode a 32-bit selection pattern picks a divider for every serial clock cycle of a transfer. A clear pattern bit picks the first divider and a set bit picks the second. Cycle n of a transfer uses pattern bit n, and after 32 cycles the index goes back to bit 0. This lets the clock period change from one cycle to the next.

While the run input is low the clock rests at a programmable idle level and the pattern index is held at zero. Two one-cycle strobes mark the rising and falling transitions so that a shifter working in the same clock domain can launch and capture data on them.

Top module: `vclk_gen`

## Requirements
- R1: While `xfer_run` is sampled low at a clock edge, `sclk` equals the `idle_level` sampled at that edge from the next cycle on, and both strobes are 0.
- R2: With `pat_en` = 0, every half period lasts `div_base`+1 clocks, whatever the values of `sel_pattern` and `div_alt`.
- R3: With `pat_en` = 1, both halves of serial cycle n last (`div_alt`+1) clocks when `sel_pattern[n]` is 1, and (`div_base`+1) clocks when it is 0. Bit 0 belongs to the first cycle.
- R4: The first transition of a transfer moves `sclk` away from the idle level. It becomes visible after the (d+1)-th clock edge at which `xfer_run` is sampled high, where d is the divider chosen for cycle 0.
- R5: A selected divider of 0 makes `sclk` change at every clock edge while running, giving one serial edge per peripheral clock.
- R6: The pattern index wraps after 32 serial cycles, so cycle 32 uses `sel_pattern[0]` again.
- R7: Every transfer starts from pattern bit 0, even when the previous transfer was stopped part way through the pattern.
- R8: `rise_stb` is 1 for exactly the one cycle in which `sclk` first shows 1 after 0, and `fall_stb` likewise for 1 to 0. The two are never 1 together, and `sclk` never changes during a run without one of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_run | input | 1 | High while serial clocking is wanted |
| pat_en | input | 1 | 1 selects pattern-driven variable period |
| idle_level | input | 1 | Resting level of `sclk` |
| div_base | input | 16 | First divider; half period = value + 1 clocks |
| div_alt | input | 16 | Second divider, used for set pattern bits |
| sel_pattern | input | 32 | Per-cycle divider choice, bit n for cycle n |
| sclk | output | 1 | Serial clock |
| rise_stb | output | 1 | One-cycle strobe on a low-to-high transition |
| fall_stb | output | 1 | One-cycle strobe on a high-to-low transition |

## Verification
The bench goes after the zero divider, the wrap from cycle 31 back to cycle 0, a restart in the middle of a pattern, and fixed mode with an all-ones pattern and a large second divider. A design that stretches the zero case to two clocks would miss edges. A design with an off-by-one wrap or a stale index would use the wrong pattern bit and shift every later edge. A design that leaks the pattern into fixed mode would show long halves where short ones are expected. Randomized transfers mix both idle levels and small divider pairs, and the bench compares every edge time and strobe against an absolute-time reference.

// File: rtl/vclk_pkg.sv
package vclk_pkg;

  typedef enum logic {PH_LEAD = 1'b0, PH_TRAIL = 1'b1} half_e;

  // selects the second divider only in pattern mode with the bit set
  function automatic logic pick_alt(input logic pat_en, input logic pat_bit);
    return pat_en & pat_bit;
  endfunction

  // a half period ends once the count has reached the limit
  function automatic logic half_over(input logic [31:0] cnt, input logic [31:0] lim);
    return cnt >= lim;
  endfunction

  // next pattern index with wrap at the pattern width
  function automatic logic [31:0] next_index(input logic [31:0] idx, input logic [31:0] width);
    return (idx + 32'd1 >= width) ? 32'd0 : idx + 32'd1;
  endfunction

endpackage

// File: rtl/vclk_selector.sv
module vclk_selector
  import vclk_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int PAT_W = 32,
  localparam int IDX_W = (PAT_W > 1) ? $clog2(PAT_W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cycle_end,
  input  logic             pat_en,
  input  logic [PAT_W-1:0] pattern,
  input  logic [DIV_W-1:0] div_a,
  input  logic [DIV_W-1:0] div_b,
  output logic [DIV_W-1:0] cur_div,
  output logic [IDX_W-1:0] idx
);

  localparam bool_pow2 = (PAT_W == (1 << IDX_W));

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_step;
  logic             use_alt;

  generate
    if (bool_pow2) begin : g_natural_wrap
      assign idx_step = idx_q + IDX_W'(1);
    end else begin : g_compare_wrap
      logic [31:0] nxt;
      assign nxt      = next_index(32'(idx_q), 32'(PAT_W));
      assign idx_step = nxt[IDX_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)         idx_q <= '0;
    else if (!run)      idx_q <= '0;
    else if (cycle_end) idx_q <= idx_step;
  end

  assign use_alt = pick_alt(pat_en, pattern[idx_q]);
  assign cur_div = use_alt ? div_b : div_a;
  assign idx     = idx_q;

endmodule

// File: rtl/vclk_timer.sv
module vclk_timer
  import vclk_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] lim,
  output logic             toggle,
  output logic             cycle_end
);

  logic [DIV_W-1:0] cnt_q;
  half_e            ph_q;

  assign toggle    = run && half_over(32'(cnt_q), 32'(lim));
  assign cycle_end = toggle && (ph_q == PH_TRAIL);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q <= '0;
      ph_q  <= PH_LEAD;
    end else if (toggle) begin
      cnt_q <= '0;
      ph_q  <= (ph_q == PH_LEAD) ? PH_TRAIL : PH_LEAD;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

endmodule

// File: rtl/vclk_drive.sv
module vclk_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic idle_level,
  input  logic toggle,
  output logic sclk,
  output logic rise_stb,
  output logic fall_stb
);

  logic sclk_q, rise_q, fall_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else if (!run) begin
      sclk_q <= idle_level;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      sclk_q <= toggle ? ~sclk_q : sclk_q;
      rise_q <= toggle & ~sclk_q;
      fall_q <= toggle & sclk_q;
    end
  end

  assign sclk     = sclk_q;
  assign rise_stb = rise_q;
  assign fall_stb = fall_q;

endmodule

// File: rtl/vclk_gen.sv
module vclk_gen #(
  parameter int DIV_W = 16,
  parameter int PAT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_run,
  input  logic             pat_en,
  input  logic             idle_level,
  input  logic [DIV_W-1:0] div_base,
  input  logic [DIV_W-1:0] div_alt,
  input  logic [PAT_W-1:0] sel_pattern,
  output logic             sclk,
  output logic             rise_stb,
  output logic             fall_stb
);

  localparam int IDX_W = (PAT_W > 1) ? $clog2(PAT_W) : 1;

  logic [DIV_W-1:0] cur_div;
  logic [IDX_W-1:0] pat_idx;
  logic             half_toggle;
  logic             cycle_end;

  vclk_selector #(.DIV_W(DIV_W), .PAT_W(PAT_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .run(xfer_run), .cycle_end(cycle_end),
    .pat_en(pat_en), .pattern(sel_pattern), .div_a(div_base), .div_b(div_alt),
    .cur_div(cur_div), .idx(pat_idx)
  );

  vclk_timer #(.DIV_W(DIV_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(xfer_run), .lim(cur_div),
    .toggle(half_toggle), .cycle_end(cycle_end)
  );

  vclk_drive u_drv (
    .clk(clk), .rst_n(rst_n), .run(xfer_run), .idle_level(idle_level),
    .toggle(half_toggle), .sclk(sclk), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

endmodule

// File: rtl/vclk_gen_chk.sv
module vclk_gen_chk #(
  parameter int DIV_W = 16,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             xfer_run,
  input logic             pat_en,
  input logic             idle_level,
  input logic [DIV_W-1:0] div_base,
  input logic             sclk,
  input logic             rise_stb,
  input logic             fall_stb,
  input logic [IDX_W-1:0] pat_idx
);

  p_idle_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_run |=> (sclk == $past(idle_level)) && !rise_stb && !fall_stb);

  p_index_home_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_run |=> pat_idx == '0);

  p_zero_div_every_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_run && !pat_en && div_base == '0) |=> sclk != $past(sclk));

  p_rise_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> sclk && !$past(sclk));

  p_fall_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> !sclk && $past(sclk));

  p_strobes_apart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_stb && fall_stb));

  p_move_needs_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(xfer_run) && sclk != $past(sclk)) |-> (rise_stb || fall_stb));

endmodule

bind vclk_gen vclk_gen_chk #(.DIV_W(DIV_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_run(xfer_run), .pat_en(pat_en),
  .idle_level(idle_level), .div_base(div_base), .sclk(sclk),
  .rise_stb(rise_stb), .fall_stb(fall_stb), .pat_idx(pat_idx)
);

// File: tb/vclk_gen_bench.sv
`timescale 1ns/1ps
module vclk_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xfer_run = 1'b0;
  logic        pat_en = 1'b0;
  logic        idle_level = 1'b0;
  logic [15:0] div_base = '0;
  logic [15:0] div_alt = '0;
  logic [31:0] sel_pattern = '0;
  logic        sclk, rise_stb, fall_stb;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  vclk_gen u_vclk_gen (
    .clk(clk), .rst_n(rst_n), .xfer_run(xfer_run), .pat_en(pat_en),
    .idle_level(idle_level), .div_base(div_base), .div_alt(div_alt),
    .sel_pattern(sel_pattern), .sclk(sclk), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference half length in clocks for serial cycle n
  function automatic int half_len(input bit ve, input int da, input int db,
                                  input logic [31:0] pat, input int n);
    return (ve && pat[n % 32]) ? db + 1 : da + 1;
  endfunction

  // one transfer of ncyc serial cycles, checked edge by edge in absolute time
  task automatic xfer(input bit ve, input bit ip, input int da, input int db,
                      input logic [31:0] pat, input int ncyc, input string tag);
    int k, half, nxt;
    bit lvl, er, ef;
    @(negedge clk);
    xfer_run = 1'b0; pat_en = ve; idle_level = ip;
    div_base = 16'(da); div_alt = 16'(db); sel_pattern = pat;
    repeat (2) @(negedge clk);
    chk(sclk == ip, "R1 idle before run", sclk, ip);
    xfer_run = 1'b1;
    k = 0; half = 0; lvl = ip;
    nxt = half_len(ve, da, db, pat, 0);
    while (half < 2 * ncyc) begin
      @(negedge clk);
      k++;
      er = 0; ef = 0;
      if (k == nxt) begin
        lvl = !lvl; er = lvl; ef = !lvl; half++;
        nxt += half_len(ve, da, db, pat, half / 2);
      end
      chk(sclk == lvl, {tag, " sclk R4"}, sclk, lvl);
      chk(rise_stb == er, {tag, " rise R8"}, rise_stb, er);
      chk(fall_stb == ef, {tag, " fall R8"}, fall_stb, ef);
    end
    xfer_run = 1'b0;
    @(negedge clk);
    chk(sclk == ip, "R1 idle after stop", sclk, ip);
    chk(!rise_stb && !fall_stb, "R1 no strobe when stopped", rise_stb + fall_stb, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk(sclk == 1'b0 && !rise_stb && !fall_stb, "reset state", sclk, 0);
    rst_n = 1'b1;
    // R1: idle follows idle_level, and changing dividers and pattern while stopped has no effect
    idle_level = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(sclk == 1'b1, "R1 idle high", sclk, 1);
    for (int i = 0; i < 6; i++) begin
      div_base = 16'($urandom); sel_pattern = $urandom; pat_en = i[0];
      @(negedge clk);
      chk(sclk == 1'b1 && !rise_stb && !fall_stb, "R1 stopped ignores settings", sclk, 1);
    end
    // R2: fixed mode ignores an all-ones pattern and a large second divider
    xfer(1'b0, 1'b0, 2, 40, 32'hFFFF_FFFF, 4, "R2 fixed");
    // R5: zero divider, both idle levels
    xfer(1'b0, 1'b0, 0, 7, 32'h0, 5, "R5 zero");
    xfer(1'b1, 1'b1, 0, 0, 32'hA5A5_A5A5, 4, "R5 zero both");
    // R3: alternating pattern between two dividers
    xfer(1'b1, 1'b0, 1, 4, 32'h0000_00A6, 9, "R3 mixed");
    // R6: wrap after 32 cycles, only bit 0 slows the clock
    xfer(1'b1, 1'b1, 1, 3, 32'h0000_0001, 34, "R6 wrap");
    xfer(1'b1, 1'b0, 0, 2, 32'h8000_0001, 33, "R6 wrap edge bits");
    // R7: stop mid-pattern, restart must begin at bit 0
    xfer(1'b1, 1'b0, 0, 3, 32'h0000_00F0, 5, "R7 part");
    xfer(1'b1, 1'b0, 0, 3, 32'h0000_00F0, 6, "R7 restart");
    // constrained random transfers
    for (int t = 0; t < 12; t++) begin
      xfer(1'($urandom), 1'($urandom), int'($urandom_range(0, 4)),
           int'($urandom_range(0, 4)), $urandom, int'($urandom_range(2, 36)), "R3 random");
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule